// File: doc/BRIEF.md
# Retired-Instruction Trap Matcher

This block sits beside the commit stage of an out-of-order core and decides, for each instruction as it retires, whether a trap chosen by software should be raised. Software programs a small table of trap definitions at run time. Each definition names an instruction, or a whole class of instructions, and may add conditions on how a branch behaved. When the retiring instruction satisfies any valid definition, the block raises a trap request. The core takes that request through the same exception entry point it uses for system calls.

In the same cycle, the block copies the retiring instruction's attributes into a retired-entry buffer. The trap handler reads this buffer to see what caused the trap. While a trap is waiting for the handler, the buffer stops updating, so the handler always sees the instruction that trapped. The handler's acknowledge releases both the trap request and the buffer.

An identification byte splits into two fields. The class sits in bits 7:6: 00 control, 01 load/store, 10 integer arithmetic/logic, 11 miscellaneous. The opcode sits in bits 5:0. Each bit of the behaviour byte names one condition:

| Bit | Condition |
|-----|-----------|
| 0 | not taken |
| 1 | taken |
| 2 | forward |
| 3 | backward |
| 4 | unconditional |
| 5 | indirect |
| 6 | return |
| 7 | reserved |

Top module: `retire_trap_matcher`

## Requirements
- R1: After reset, `trap_req` is 0, `rrb_valid` is 0 and every table entry reads back with `sw_rd_valid` = 0.
- R2: A cycle with `sw_wr_en` = 1 stores `sw_wr_valid`, `sw_wr_id` and `sw_wr_beh` into the entry selected by `sw_idx`. The same index returns the stored entry combinationally on `sw_rd_valid`, `sw_rd_id` and `sw_rd_beh`.
- R3: An entry whose opcode field (id bits 5:0) is zero matches every retiring instruction whose class equals id bits 7:6. Class encoding is 00 control, 01 load/store, 10 arithmetic/logic, 11 miscellaneous.
- R4: An entry with a nonzero opcode field matches only when both the class and the 6-bit opcode are equal to those of the retiring instruction.
- R5: When behaviour bits 6:0 are all zero, the entry matches on every occurrence of the identified instructions. Behaviour bit 7 never affects matching.
- R6: Otherwise, the behaviour conditions fall into three groups. Outcome is bit 0 (not taken) and bit 1 (taken). Direction is bit 2 (forward) and bit 3 (backward). Kind is bits 4, 5 and 6, compared against `cmt_kind` bits 0, 1 and 2 (unconditional, indirect, return). Each group that has any bit set must be satisfied by at least one of its set bits.
- R7: An entry whose valid bit is 0 never raises a trap, whatever its id and behaviour fields hold.
- R8: A matching commit in cycle N drives `trap_req` = 1 from cycle N+1, with `trap_pc` equal to the committing PC.
- R9: `trap_req` stays at 1 with `trap_pc` unchanged until a cycle with `trap_ack` = 1, and is 0 in the next cycle. Commits that retire while the request is pending, including in the acknowledge cycle, raise no trap.
- R10: Each commit that is not blocked by a pending trap appears on the `rrb_*` outputs in the next cycle, with `rrb_valid` = 1.
- R11: While `trap_req` = 1 and `trap_ack` = 0, commits leave the `rrb_*` outputs unchanged. A commit in the acknowledge cycle is captured.
- R12: A cycle with `cmt_valid` = 0 neither raises a trap nor changes the retired-entry buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_valid | input | 1 | An instruction retires this cycle |
| cmt_pc | input | PC_W | PC of the retiring instruction |
| cmt_class | input | 2 | Class of the retiring instruction |
| cmt_opcode | input | 6 | Opcode of the retiring instruction |
| cmt_taken | input | 1 | Branch was taken |
| cmt_backward | input | 1 | Branch target lies behind the PC |
| cmt_kind | input | 3 | One-hot kind: bit0 unconditional, bit1 indirect, bit2 return |
| sw_idx | input | IDX_W | Table index for write and readback |
| sw_wr_en | input | 1 | Write the selected entry |
| sw_wr_valid | input | 1 | Valid bit to store |
| sw_wr_id | input | 8 | Identification byte to store |
| sw_wr_beh | input | 8 | Behaviour byte to store |
| sw_rd_valid | output | 1 | Valid bit of the selected entry |
| sw_rd_id | output | 8 | Identification byte of the selected entry |
| sw_rd_beh | output | 8 | Behaviour byte of the selected entry |
| trap_ack | input | 1 | Handler has taken the pending trap |
| trap_req | output | 1 | Trap request to the exception logic |
| trap_pc | output | PC_W | PC of the trapping instruction |
| rrb_valid | output | 1 | Buffer holds a retired instruction |
| rrb_pc | output | PC_W | Buffered PC |
| rrb_class | output | 2 | Buffered class |
| rrb_opcode | output | 6 | Buffered opcode |
| rrb_taken | output | 1 | Buffered taken flag |
| rrb_backward | output | 1 | Buffered backward flag |
| rrb_kind | output | 3 | Buffered branch kind |

## Verification
The assertions assume that `trap_ack` is raised only while `trap_req` is 1, and that at most one instruction retires per cycle on the commit port. The bench follows both rules: it asserts acknowledge for a single cycle, and only after it has observed a pending trap. It drives commits one per cycle and programs the table only while no commit is in flight. The branch attributes are driven in every class, so that non-branch classes exercise the behaviour groups as well.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int CLS_W  = 2;
    localparam int OPC_W  = 6;
    localparam int ID_W   = CLS_W + OPC_W;
    localparam int BEH_W  = 8;
    localparam int KIND_W = 3;
    localparam int COND_W = BEH_W - 1;

    // behaviour bit positions; matching depends on these groupings
    localparam int B_NTAKEN = 0;
    localparam int B_TAKEN  = 1;
    localparam int B_FWD    = 2;
    localparam int B_BWD    = 3;
    localparam int B_KIND0  = 4;

    typedef struct packed {
        logic [CLS_W-1:0]  cls;
        logic [OPC_W-1:0]  opc;
        logic              taken;
        logic              backward;
        logic [KIND_W-1:0] kind;
    } insn_attr_t;

    typedef struct packed {
        logic              vld;
        logic [ID_W-1:0]   id;
        logic [BEH_W-1:0]  beh;
    } tdef_t;

endpackage

// File: rtl/trap_def_table.sv
module trap_def_table
    import trap_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      idx,
    input  tdef_t                 wr_entry,
    output tdef_t                 rd_entry,
    output tdef_t [N_ENT-1:0]     entries
);

    typedef struct packed {
        tdef_t [N_ENT-1:0] ent;
    } tbl_state_t;

    tbl_state_t st_d, st_q;
    logic       idx_in_range;

    assign idx_in_range = (32'(idx) < N_ENT);

    always_comb begin
        st_d = st_q;
        if (wr_en && idx_in_range) begin
            st_d.ent[idx] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_entry = idx_in_range ? st_q.ent[idx] : '0;
    assign entries  = st_q.ent;

endmodule

// File: rtl/trap_entry_match.sv
module trap_entry_match
    import trap_pkg::*;
(
    input  logic              vld,
    input  logic [ID_W-1:0]   id,
    input  logic [COND_W-1:0] cond,
    input  insn_attr_t        attr,
    output logic              hit
);

    logic [CLS_W-1:0]  id_cls;
    logic [OPC_W-1:0]  id_opc;
    logic [1:0]        out_grp;
    logic [1:0]        dir_grp;
    logic [KIND_W-1:0] kind_grp;
    logic              cls_ok;
    logic              opc_ok;
    logic              out_ok;
    logic              dir_ok;
    logic              kind_ok;

    always_comb begin
        id_cls   = id[ID_W-1 -: CLS_W];
        id_opc   = id[OPC_W-1:0];
        out_grp  = cond[B_TAKEN:B_NTAKEN];
        dir_grp  = cond[B_BWD:B_FWD];
        kind_grp = cond[B_KIND0 +: KIND_W];

        cls_ok  = (id_cls == attr.cls);
        opc_ok  = (id_opc == '0) || (id_opc == attr.opc);

        out_ok  = (out_grp == '0)
               || (out_grp[0] && !attr.taken)
               || (out_grp[1] &&  attr.taken);
        dir_ok  = (dir_grp == '0)
               || (dir_grp[0] && !attr.backward)
               || (dir_grp[1] &&  attr.backward);
        kind_ok = (kind_grp == '0) || ((kind_grp & attr.kind) != '0);

        hit = vld && cls_ok && opc_ok && out_ok && dir_ok && kind_ok;
    end

endmodule

// File: rtl/retired_entry_buffer.sv
module retired_entry_buffer
    import trap_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [PC_W-1:0] pc_in,
    input  insn_attr_t      attr_in,
    output logic            vld,
    output logic [PC_W-1:0] pc,
    output insn_attr_t      attr
);

    typedef struct packed {
        logic            vld;
        logic [PC_W-1:0] pc;
        insn_attr_t      attr;
    } rrb_state_t;

    rrb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.vld  = 1'b1;
            st_d.pc   = pc_in;
            st_d.attr = attr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld  = st_q.vld;
    assign pc   = st_q.pc;
    assign attr = st_q.attr;

endmodule

// File: rtl/retire_trap_matcher.sv
module retire_trap_matcher
    import trap_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int N_ENT = 8,
    parameter int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmt_valid,
    input  logic [PC_W-1:0]   cmt_pc,
    input  logic [CLS_W-1:0]  cmt_class,
    input  logic [OPC_W-1:0]  cmt_opcode,
    input  logic              cmt_taken,
    input  logic              cmt_backward,
    input  logic [KIND_W-1:0] cmt_kind,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic              sw_wr_en,
    input  logic              sw_wr_valid,
    input  logic [ID_W-1:0]   sw_wr_id,
    input  logic [BEH_W-1:0]  sw_wr_beh,
    output logic              sw_rd_valid,
    output logic [ID_W-1:0]   sw_rd_id,
    output logic [BEH_W-1:0]  sw_rd_beh,
    input  logic              trap_ack,
    output logic              trap_req,
    output logic [PC_W-1:0]   trap_pc,
    output logic              rrb_valid,
    output logic [PC_W-1:0]   rrb_pc,
    output logic [CLS_W-1:0]  rrb_class,
    output logic [OPC_W-1:0]  rrb_opcode,
    output logic              rrb_taken,
    output logic              rrb_backward,
    output logic [KIND_W-1:0] rrb_kind
);

    typedef struct packed {
        logic            req;
        logic [PC_W-1:0] pc;
    } trap_state_t;

    insn_attr_t         cmt_attr;
    tdef_t              wr_entry;
    tdef_t              rd_entry;
    tdef_t [N_ENT-1:0]  entries;
    logic  [N_ENT-1:0]  ent_hit;
    logic               any_hit;
    logic               capture;
    insn_attr_t         rrb_attr;
    trap_state_t        tr_d, tr_q;

    assign cmt_attr = '{cls: cmt_class, opc: cmt_opcode, taken: cmt_taken,
                        backward: cmt_backward, kind: cmt_kind};
    assign wr_entry = '{vld: sw_wr_valid, id: sw_wr_id, beh: sw_wr_beh};

    trap_def_table #(
        .N_ENT (N_ENT),
        .IDX_W (IDX_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sw_wr_en),
        .idx      (sw_idx),
        .wr_entry (wr_entry),
        .rd_entry (rd_entry),
        .entries  (entries)
    );

    assign sw_rd_valid = rd_entry.vld;
    assign sw_rd_id    = rd_entry.id;
    assign sw_rd_beh   = rd_entry.beh;

    // one comparator per table entry, all evaluated in parallel
    for (genvar g = 0; g < N_ENT; g++) begin : g_match
        trap_entry_match u_match (
            .vld  (entries[g].vld),
            .id   (entries[g].id),
            .cond (entries[g].beh[COND_W-1:0]),
            .attr (cmt_attr),
            .hit  (ent_hit[g])
        );
    end

    assign any_hit = |ent_hit;

    // trap request state: one pending trap at a time
    always_comb begin
        tr_d = tr_q;
        if (tr_q.req) begin
            if (trap_ack) begin
                tr_d.req = 1'b0;
            end
        end else if (cmt_valid && any_hit) begin
            tr_d.req = 1'b1;
            tr_d.pc  = cmt_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tr_q <= '0;
        end else begin
            tr_q <= tr_d;
        end
    end

    assign trap_req = tr_q.req;
    assign trap_pc  = tr_q.pc;

    // buffer is frozen while a trap waits, released in the acknowledge cycle
    assign capture = cmt_valid && (!tr_q.req || trap_ack);

    retired_entry_buffer #(
        .PC_W (PC_W)
    ) u_rrb (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .pc_in   (cmt_pc),
        .attr_in (cmt_attr),
        .vld     (rrb_valid),
        .pc      (rrb_pc),
        .attr    (rrb_attr)
    );

    assign rrb_class    = rrb_attr.cls;
    assign rrb_opcode   = rrb_attr.opc;
    assign rrb_taken    = rrb_attr.taken;
    assign rrb_backward = rrb_attr.backward;
    assign rrb_kind     = rrb_attr.kind;

endmodule

// File: rtl/retire_trap_matcher_chk.sv
module retire_trap_matcher_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmt_valid,
    input logic [PC_W-1:0] cmt_pc,
    input logic            trap_ack,
    input logic            trap_req,
    input logic [PC_W-1:0] trap_pc,
    input logic            rrb_valid,
    input logic [PC_W-1:0] rrb_pc
);

    AST_TRAP_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_req) |-> ($past(cmt_valid) && trap_pc == $past(cmt_pc))); // R8

    AST_TRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> (trap_req && $stable(trap_pc))); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_ack) |=> !trap_req); // R9

    AST_RRB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && (!trap_req || trap_ack)) |=> (rrb_valid && rrb_pc == $past(cmt_pc))); // R10

    AST_RRB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> $stable(rrb_pc)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmt_valid && !trap_req) |=> (!trap_req && $stable(rrb_pc))); // R12

endmodule

bind retire_trap_matcher retire_trap_matcher_chk #(.PC_W(PC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmt_valid (cmt_valid),
    .cmt_pc    (cmt_pc),
    .trap_ack  (trap_ack),
    .trap_req  (trap_req),
    .trap_pc   (trap_pc),
    .rrb_valid (rrb_valid),
    .rrb_pc    (rrb_pc)
);

// File: tb/retire_trap_matcher_bench.sv
module retire_trap_matcher_bench;

    localparam int PC_W  = 32;
    localparam int N_ENT = 8;
    localparam int IDX_W = 3;
    localparam int NVEC  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmt_valid = 1'b0;
    logic [PC_W-1:0]   cmt_pc = '0;
    logic [1:0]        cmt_class = '0;
    logic [5:0]        cmt_opcode = '0;
    logic              cmt_taken = 1'b0;
    logic              cmt_backward = 1'b0;
    logic [2:0]        cmt_kind = '0;
    logic [IDX_W-1:0]  sw_idx = '0;
    logic              sw_wr_en = 1'b0;
    logic              sw_wr_valid = 1'b0;
    logic [7:0]        sw_wr_id = '0;
    logic [7:0]        sw_wr_beh = '0;
    logic              sw_rd_valid;
    logic [7:0]        sw_rd_id;
    logic [7:0]        sw_rd_beh;
    logic              trap_ack = 1'b0;
    logic              trap_req;
    logic [PC_W-1:0]   trap_pc;
    logic              rrb_valid;
    logic [PC_W-1:0]   rrb_pc;
    logic [1:0]        rrb_class;
    logic [5:0]        rrb_opcode;
    logic              rrb_taken;
    logic              rrb_backward;
    logic [2:0]        rrb_kind;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    retire_trap_matcher #(.PC_W(PC_W), .N_ENT(N_ENT), .IDX_W(IDX_W)) u_retire_trap_matcher (
        .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_pc(cmt_pc),
        .cmt_class(cmt_class), .cmt_opcode(cmt_opcode), .cmt_taken(cmt_taken),
        .cmt_backward(cmt_backward), .cmt_kind(cmt_kind), .sw_idx(sw_idx),
        .sw_wr_en(sw_wr_en), .sw_wr_valid(sw_wr_valid), .sw_wr_id(sw_wr_id),
        .sw_wr_beh(sw_wr_beh), .sw_rd_valid(sw_rd_valid), .sw_rd_id(sw_rd_id),
        .sw_rd_beh(sw_rd_beh), .trap_ack(trap_ack), .trap_req(trap_req),
        .trap_pc(trap_pc), .rrb_valid(rrb_valid), .rrb_pc(rrb_pc),
        .rrb_class(rrb_class), .rrb_opcode(rrb_opcode), .rrb_taken(rrb_taken),
        .rrb_backward(rrb_backward), .rrb_kind(rrb_kind)
    );

    // vector: {expect_trap, kind[2:0], backward, taken, class[1:0], opcode[5:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 3'b000, 1'b0, 1'b0, 2'b01, 6'h28},
        {1'b1, 3'b000, 1'b1, 1'b1, 2'b01, 6'h2C},
        {1'b1, 3'b000, 1'b1, 1'b1, 2'b00, 6'h39},
        {1'b0, 3'b000, 1'b0, 1'b1, 2'b00, 6'h39},
        {1'b0, 3'b000, 1'b1, 1'b0, 2'b00, 6'h39},
        {1'b1, 3'b001, 1'b0, 1'b1, 2'b00, 6'h30},
        {1'b1, 3'b100, 1'b1, 1'b1, 2'b00, 6'h30},
        {1'b0, 3'b010, 1'b0, 1'b1, 2'b00, 6'h30},
        {1'b0, 3'b001, 1'b0, 1'b1, 2'b00, 6'h31},
        {1'b0, 3'b000, 1'b0, 1'b0, 2'b10, 6'h05},
        {1'b1, 3'b010, 1'b1, 1'b1, 2'b11, 6'h18},
        {1'b0, 3'b000, 1'b0, 1'b0, 2'b11, 6'h19},
        {1'b1, 3'b000, 1'b0, 1'b0, 2'b10, 6'h10},
        {1'b0, 3'b000, 1'b0, 1'b1, 2'b10, 6'h10},
        {1'b0, 3'b000, 1'b0, 1'b0, 2'b00, 6'h28},
        {1'b1, 3'b100, 1'b1, 1'b1, 2'b01, 6'h20}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:               return "R3";
            8, 11, 14:          return "R4";
            10, 15:             return "R5";
            9:                  return "R7";
            default:            return "R6";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic sw_write(input int idx, input logic v, input logic [7:0] id,
                            input logic [7:0] beh);
        @(negedge clk);
        sw_idx = IDX_W'(idx); sw_wr_valid = v; sw_wr_id = id; sw_wr_beh = beh;
        sw_wr_en = 1'b1;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    // drives one commit; returns at the negedge after the capturing edge
    task automatic commit(input logic [PC_W-1:0] pc, input logic [13:0] v,
                          input logic ack);
        @(negedge clk);
        cmt_pc = pc; cmt_opcode = v[5:0]; cmt_class = v[7:6];
        cmt_taken = v[8]; cmt_backward = v[9]; cmt_kind = v[12:10];
        cmt_valid = 1'b1; trap_ack = ack;
        @(negedge clk);
        cmt_valid = 1'b0; trap_ack = 1'b0;
    endtask

    task automatic ack_trap;
        @(negedge clk);
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "trap_req", 64'(trap_req), 64'd0);
        check("R1", "rrb_valid", 64'(rrb_valid), 64'd0);
        for (int i = 0; i < N_ENT; i++) begin
            sw_idx = IDX_W'(i); #1;
            check("R1", "entry valid", 64'(sw_rd_valid), 64'd0);
        end

        // program the table
        sw_write(0, 1'b1, 8'h40, 8'h00);   // all load/store
        sw_write(1, 1'b1, 8'h39, 8'h0A);   // control 0x39, taken and backward
        sw_write(2, 1'b1, 8'h30, 8'h50);   // control 0x30, unconditional or return
        sw_write(3, 1'b0, 8'h80, 8'h00);   // invalid: all arith
        sw_write(4, 1'b1, 8'hD8, 8'h80);   // misc 0x18, only reserved bit
        sw_write(5, 1'b1, 8'h90, 8'h01);   // arith 0x10, not taken

        // R2 readback
        @(negedge clk);
        sw_idx = 3'd1; #1;
        check("R2", "rd valid", 64'(sw_rd_valid), 64'd1);
        check("R2", "rd id", 64'(sw_rd_id), 64'h39);
        check("R2", "rd beh", 64'(sw_rd_beh), 64'h0A);
        sw_idx = 3'd3; #1;
        check("R2", "rd valid", 64'(sw_rd_valid), 64'd0);
        check("R2", "rd id", 64'(sw_rd_id), 64'h80);

        // vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [PC_W-1:0] pc;
            pc = 32'h1000 + 32'(i * 4);
            commit(pc, VEC[i], 1'b0);
            check(vec_tag(i), $sformatf("trap vec %0d", i), 64'(trap_req), 64'(VEC[i][13]));
            check("R10", $sformatf("rrb_pc vec %0d", i), 64'(rrb_pc), 64'(pc));
            check("R10", $sformatf("rrb fields vec %0d", i),
                  64'({rrb_kind, rrb_backward, rrb_taken, rrb_class, rrb_opcode}),
                  64'(VEC[i][12:0]));
            if (VEC[i][13]) begin
                check("R8", $sformatf("trap_pc vec %0d", i), 64'(trap_pc), 64'(pc));
                ack_trap();
                check("R9", $sformatf("cleared vec %0d", i), 64'(trap_req), 64'd0);
            end
        end

        // R12: matching attributes with no commit
        @(negedge clk);
        cmt_valid = 1'b0; cmt_class = 2'b01; cmt_opcode = 6'h28; cmt_pc = 32'h3000;
        repeat (3) @(negedge clk);
        check("R12", "no trap idle", 64'(trap_req), 64'd0);
        check("R12", "rrb unchanged", 64'(rrb_pc), 64'h103C);

        // R9 / R11: freeze while pending, release in ack cycle
        commit(32'h2000, {1'b1, 3'b000, 1'b0, 1'b0, 2'b01, 6'h28}, 1'b0);
        check("R8", "trap raised", 64'(trap_req), 64'd1);
        commit(32'h2004, {1'b1, 3'b000, 1'b0, 1'b0, 2'b01, 6'h29}, 1'b0);
        check("R9", "still pending", 64'(trap_req), 64'd1);
        check("R9", "trap_pc held", 64'(trap_pc), 64'h2000);
        check("R11", "rrb frozen", 64'(rrb_pc), 64'h2000);
        commit(32'h2008, {1'b1, 3'b000, 1'b0, 1'b0, 2'b01, 6'h2A}, 1'b1);
        check("R9", "ack clears, no new trap", 64'(trap_req), 64'd0);
        check("R11", "rrb resumes in ack cycle", 64'(rrb_pc), 64'h2008);

        // R7: invalidate entry 0 and recheck a load
        sw_write(0, 1'b0, 8'h40, 8'h00);
        commit(32'h2100, {1'b0, 3'b000, 1'b0, 1'b0, 2'b01, 6'h28}, 1'b0);
        check("R7", "invalidated entry", 64'(trap_req), 64'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule